// File: doc/BRIEF.md
# Watchdog Timer with Self-Test

This block is a watchdog counter with a 32-bit time-out value that is split into four byte lanes. When the counter reaches the programmed time-out, the block raises a single-cycle reset request and starts counting again from zero. A 16-bit control register holds the enable, lock and mode bits. Software writes it through a plain write strobe and reads it back at all times.

A functional self-test mode switches the counter from the normal tick enable to a fast test tick enable. Two tests are available. The quick test runs the full 32-bit comparison, so a small time-out value expires soon. The byte test runs only one selected byte lane of the counter, wrapping at 8 bits, and compares it against the matching byte of the time-out value. This exercises each slice of the compare and reset path on its own. A test-disable bit can be set once and then stays set until reset. While it is set, test mode cannot be entered. Clearing the update-permit bit locks the rest of the register.

Top module: `wdt_selftest`

## Requirements
- R1: After reset the control register reads 16'h01D3. That value is bits 0, 1, 4, 6, 7 and 8 set and all other bits clear. Bit 15 always reads 0, whatever is written to it.
- R2: While bit 4 (update permit) is 1, a write replaces bits 13:0 with the written data, subject to R4 and R5. The new value reads back from the cycle after the write.
- R3: Once bit 4 is 0, writes leave bits 13:0 unchanged, except that bit 14 can still be set to 1.
- R4: Bit 14 (test disable) stays 1 from the write that sets it until reset. Writing 0 to it has no effect.
- R5: Bit 10 (test mode) always reads 0 while bit 14 is 1. A write that sets bit 10 is ignored if bit 14 is already 1 or is set in the same write. Setting bit 14 clears bit 10.
- R6: With bit 10 clear the counter advances only on cycles where tick_norm is high. With bit 10 set it advances only on cycles where tick_fast is high.
- R7: In normal mode and in quick test (bit 11 = 0), each tick adds 1 to the 32-bit count. On the tick where count+1 equals tmo_value, the count becomes 0 and rst_req is high for the next cycle.
- R8: In byte test (bits 10 and 11 both 1), only byte lane bits 13:12 counts on a tick. The code 00 selects bits 7:0 and the code 11 selects bits 31:24. The lane wraps at 8 bits with no carry, and the other three lanes hold their value.
- R9: In byte test, on the tick where the selected lane's incremented value equals the same byte of tmo_value, that lane becomes 0 and rst_req is high for the next cycle.
- R10: While bit 10 is 0, bit 11 has no effect: the counter runs the full 32-bit compare.
- R11: While bit 0 (enable) is 0, the count is held at 0 and rst_req stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register read value |
| tmo_value | input | 32 | Time-out value, four byte lanes |
| tick_norm | input | 1 | Normal watchdog tick enable |
| tick_fast | input | 1 | Fast test tick enable |
| count_out | output | 32 | Current counter value |
| rst_req | output | 1 | Single-cycle reset request |

## Verification
A control write takes effect at the clock edge that samples the strobe, so its readback is due one cycle later. A tick changes count_out at the edge that samples it. A time-out drives rst_req high for exactly the following cycle. Every stimulus in the bench is driven on a falling edge and lasts one cycle. Each check samples on the next falling edge, which falls inside the cycle where the result is due. When ticks are applied one by one, rst_req is sampled after every single tick, so an early or late request is seen.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CTL_W  = 16;
    localparam int CNT_W  = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = CNT_W / LANE_W;
    localparam int SEL_W  = $clog2(LANES);

    // Control register layout, bit 15 first
    typedef struct packed {
        logic       rsv15;
        logic       test_off;
        logic [1:0] lane;
        logic       byte_mode;
        logic       test_on;
        logic       spare9;
        logic       spare8;
        logic       wait_en;
        logic       stop_en;
        logic       dbg_en;
        logic       upd_ok;
        logic       win_en;
        logic       early_irq_en;
        logic       tick_src;
        logic       run_en;
    } ctl_t;

    localparam logic [CTL_W-1:0] CTL_RST = 16'h01D3;

    // Applies the fixed rules that every register update must obey
    function automatic ctl_t ctl_fix(input ctl_t c);
        ctl_t r;
        r = c;
        r.rsv15 = 1'b0;
        if (r.test_off) r.test_on = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl
);

    ctl_t ctl_q;
    ctl_t ctl_d;
    ctl_t wr;

    assign wr = ctl_t'(wdata);

    always_comb begin
        ctl_d = ctl_q;
        if (we) begin
            if (ctl_q.upd_ok) begin
                ctl_d = wr;
            end
            ctl_d.test_off = ctl_q.test_off | wr.test_off;
        end
        ctl_d = ctl_fix(ctl_d);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= ctl_t'(CTL_RST);
        else     ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

    // R4: the disable latch never falls without a reset
    assert_testoff_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        ctl_q.test_off |=> ctl_q.test_off);

    // R5: test mode and the disable latch never coexist
    assert_no_test_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        ctl_q.test_off |-> !ctl_q.test_on);

    // R3: a locked register keeps every field other than the two test bits
    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.upd_ok |=> $stable({ctl_q.lane, ctl_q.byte_mode, ctl_q.spare9,
                                   ctl_q.spare8, ctl_q.wait_en, ctl_q.stop_en,
                                   ctl_q.dbg_en, ctl_q.upd_ok, ctl_q.win_en,
                                   ctl_q.early_irq_en, ctl_q.tick_src, ctl_q.run_en}));

    // R3: test mode cannot be raised while the register is locked
    assert_locked_no_test_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.upd_ok && !ctl_q.test_on) |=> !ctl_q.test_on);

endmodule

// File: rtl/wdt_tick_mux.sv
module wdt_tick_mux (
    input  logic test_on,
    input  logic tick_norm,
    input  logic tick_fast,
    output logic tick
);

    assign tick = test_on ? tick_fast : tick_norm;

endmodule

// File: rtl/wdt_lane_counter.sv
module wdt_lane_counter
    import wdt_pkg::*;
#(
    parameter int P_CNT_W  = CNT_W,
    parameter int P_LANE_W = LANE_W,
    localparam int P_LANES = P_CNT_W / P_LANE_W,
    localparam int P_SEL_W = $clog2(P_LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    input  logic               tick,
    input  logic               byte_eff,
    input  logic [P_SEL_W-1:0] lane_sel,
    input  logic [P_CNT_W-1:0] tmo,
    output logic [P_CNT_W-1:0] count,
    output logic               req
);

    logic [P_LANES-1:0][P_LANE_W-1:0] cnt_q;
    logic [P_LANES-1:0][P_LANE_W-1:0] tmo_l;
    logic [P_LANES-1:0][P_LANE_W-1:0] lane_nxt;
    logic [P_CNT_W-1:0]               full_inc;
    logic                             full_hit;
    logic                             lane_hit;
    logic                             req_q;

    assign tmo_l    = tmo;
    assign full_inc = cnt_q + P_CNT_W'(1);
    assign full_hit = (full_inc == tmo);

    for (genvar i = 0; i < P_LANES; i++) begin : g_lane
        assign lane_nxt[i] = cnt_q[i] + P_LANE_W'(1);

        // R8: lanes other than the selected one hold in byte test
        assert_frozen_lane_R8: assert property (@(posedge clk) disable iff (rst)
            (run_en && byte_eff && (lane_sel != P_SEL_W'(i))) |=> $stable(cnt_q[i]));
    end

    assign lane_hit = (lane_nxt[lane_sel] == tmo_l[lane_sel]);

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (tick) begin
                if (byte_eff) begin
                    cnt_q[lane_sel] <= lane_hit ? '0 : lane_nxt[lane_sel];
                    req_q           <= lane_hit;
                end else begin
                    cnt_q <= full_hit ? '0 : full_inc;
                    req_q <= full_hit;
                end
            end
        end
    end

    assign count = cnt_q;
    assign req   = req_q;

    // R11: a disabled watchdog sits at zero and stays silent
    assert_off_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (cnt_q == '0 && !req_q));

    // R6: without a selected tick the count does not move
    assert_tick_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (run_en && !tick) |=> $stable(cnt_q));

    // R7: a full-width time-out leaves the counter cleared
    assert_req_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (run_en && tick && !byte_eff && full_hit) |=> (cnt_q == '0 && req_q));

    // R9: a lane time-out clears the selected lane
    assert_lane_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (run_en && tick && byte_eff && lane_hit) |=> req_q);

endmodule

// File: rtl/wdt_selftest.sv
module wdt_selftest
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_we,
    input  logic [15:0] ctl_wdata,
    output logic [15:0] ctl_rdata,
    input  logic [31:0] tmo_value,
    input  logic        tick_norm,
    input  logic        tick_fast,
    output logic [31:0] count_out,
    output logic        rst_req
);

    ctl_t ctl;
    logic tick;
    logic byte_eff;

    wdt_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    wdt_tick_mux u_tick (
        .test_on   (ctl.test_on),
        .tick_norm (tick_norm),
        .tick_fast (tick_fast),
        .tick      (tick)
    );

    // R10: the test-select bit only matters inside test mode
    assign byte_eff = ctl.test_on & ctl.byte_mode;

    wdt_lane_counter #(
        .P_CNT_W  (CNT_W),
        .P_LANE_W (LANE_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run_en   (ctl.run_en),
        .tick     (tick),
        .byte_eff (byte_eff),
        .lane_sel (ctl.lane),
        .tmo      (tmo_value),
        .count    (count_out),
        .req      (rst_req)
    );

    assign ctl_rdata = ctl;

    // R1: the reserved top bit never reads as 1
    assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> !ctl_rdata[15]);

endmodule

// File: tb/wdt_selftest_bench.sv
module wdt_selftest_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic [31:0] tmo_value = '0;
    logic        tick_norm = 1'b0;
    logic        tick_fast = 1'b0;
    logic [31:0] count_out;
    logic        rst_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wdt_selftest u_wdt_selftest (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .tmo_value (tmo_value),
        .tick_norm (tick_norm),
        .tick_fast (tick_fast),
        .count_out (count_out),
        .rst_req   (rst_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ctl_we = 1'b0;
        tick_norm = 1'b0;
        tick_fast = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_ctl(input logic [15:0] d);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    // Pulses one tick input n times; reports whether rst_req was seen high
    task automatic ticks(input bit fast, input int n, output bit saw_req);
        saw_req = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (fast) tick_fast = 1'b1; else tick_norm = 1'b1;
            @(negedge clk);
            tick_fast = 1'b0;
            tick_norm = 1'b0;
            if (rst_req) saw_req = 1'b1;
        end
    endtask

    task automatic t_reset_r1();
        do_reset();
        @(negedge clk);
        chk(ctl_rdata == 16'h01D3, "R1 reset value", 32'(ctl_rdata), 32'h01D3);
        chk(count_out == 0 && !rst_req, "R1 reset counter idle", count_out, 0);
    endtask

    task automatic t_write_r2();
        do_reset();
        wr_ctl(16'hB2D5);
        chk(ctl_rdata == 16'h32D5, "R2 write readback, R1 bit15 zero",
            32'(ctl_rdata), 32'h32D5);
    endtask

    task automatic t_lock_r3_r4();
        do_reset();
        wr_ctl(16'h00C1);
        chk(ctl_rdata == 16'h00C1, "R3 lock write", 32'(ctl_rdata), 32'h00C1);
        wr_ctl(16'h0FFF);
        chk(ctl_rdata == 16'h00C1, "R3 locked write ignored", 32'(ctl_rdata), 32'h00C1);
        wr_ctl(16'h4000);
        chk(ctl_rdata == 16'h40C1, "R3 disable bit still settable", 32'(ctl_rdata), 32'h40C1);
        wr_ctl(16'h0000);
        chk(ctl_rdata == 16'h40C1, "R4 disable bit sticky", 32'(ctl_rdata), 32'h40C1);
        do_reset();
        @(negedge clk);
        chk(ctl_rdata == 16'h01D3, "R4 reset clears disable", 32'(ctl_rdata), 32'h01D3);
    endtask

    task automatic t_testoff_r5();
        do_reset();
        wr_ctl(16'h4011);
        wr_ctl(16'h4411);
        chk(ctl_rdata == 16'h4011, "R5 test blocked by earlier disable", 32'(ctl_rdata), 32'h4011);
        wr_ctl(16'h0011);
        chk(ctl_rdata == 16'h4011, "R4 clear attempt unlocked", 32'(ctl_rdata), 32'h4011);
        do_reset();
        wr_ctl(16'h4411);
        chk(ctl_rdata == 16'h4011, "R5 test blocked in same write", 32'(ctl_rdata), 32'h4011);
        do_reset();
        wr_ctl(16'h0411);
        chk(ctl_rdata == 16'h0411, "R5 test enters when allowed", 32'(ctl_rdata), 32'h0411);
        wr_ctl(16'h4411);
        chk(ctl_rdata == 16'h4011, "R5 disable drops test", 32'(ctl_rdata), 32'h4011);
    endtask

    task automatic t_ticksel_r6();
        bit r;
        do_reset();
        tmo_value = 32'd1000;
        ticks(1'b1, 5, r);
        chk(count_out == 0, "R6 fast tick ignored in normal mode", count_out, 0);
        ticks(1'b0, 3, r);
        chk(count_out == 3, "R6 normal tick counts", count_out, 3);
        wr_ctl(16'h0411);
        ticks(1'b0, 2, r);
        chk(count_out == 3, "R6 normal tick ignored in test", count_out, 3);
        ticks(1'b1, 4, r);
        chk(count_out == 7, "R6 fast tick counts in test", count_out, 7);
    endtask

    task automatic t_normal_r7();
        bit r;
        do_reset();
        tmo_value = 32'd5;
        ticks(1'b0, 4, r);
        chk(!r, "R7 no early request", 32'(r), 0);
        chk(count_out == 4, "R7 count before time-out", count_out, 4);
        ticks(1'b0, 1, r);
        chk(r, "R7 request on time-out", 32'(r), 1);
        chk(count_out == 0, "R7 count cleared", count_out, 0);
        @(negedge clk);
        chk(!rst_req, "R7 request one cycle", 32'(rst_req), 0);
        do_reset();
        tmo_value = 32'd3;
        wr_ctl(16'h0411);
        ticks(1'b1, 2, r);
        chk(!r && count_out == 2, "R7 quick test pre", count_out, 2);
        ticks(1'b1, 1, r);
        chk(r && count_out == 0, "R7 quick test time-out", {31'd0, r}, 1);
    endtask

    task automatic t_byte_r8_r9();
        bit r;
        do_reset();
        tmo_value = 32'h7700_0500;
        ticks(1'b0, 300, r);
        chk(count_out == 32'h12C, "R8 preload count", count_out, 32'h12C);
        wr_ctl(16'h1C11);
        ticks(1'b1, 3, r);
        chk(!r && count_out == 32'h0000_042C, "R8 only lane 1 counts",
            count_out, 32'h0000_042C);
        ticks(1'b1, 1, r);
        chk(r, "R9 lane time-out request", 32'(r), 1);
        chk(count_out == 32'h0000_002C, "R9 lane cleared, others held",
            count_out, 32'h0000_002C);
        wr_ctl(16'h0C11);
        ticks(1'b1, 211, r);
        chk(!r && count_out == 32'h0000_00FF, "R8 lane 0 reaches FF",
            count_out, 32'h0000_00FF);
        ticks(1'b1, 1, r);
        chk(r && count_out == 0, "R8 lane wraps with no carry", count_out, 0);
    endtask

    task automatic t_selignored_r10();
        bit r;
        do_reset();
        tmo_value = 32'h0000_0102;
        wr_ctl(16'h0811);
        ticks(1'b0, 2, r);
        chk(!r && count_out == 2, "R10 select ignored outside test", count_out, 2);
    endtask

    task automatic t_disable_r11();
        bit r;
        do_reset();
        tmo_value = 32'd2;
        wr_ctl(16'h0010);
        ticks(1'b0, 5, r);
        chk(!r && count_out == 0, "R11 disabled holds zero", count_out, 0);
        wr_ctl(16'h0011);
        ticks(1'b0, 2, r);
        chk(r, "R11 re-enabled times out", 32'(r), 1);
    endtask

    initial begin
        t_reset_r1();
        t_write_r2();
        t_lock_r3_r4();
        t_testoff_r5();
        t_ticksel_r6();
        t_normal_r7();
        t_byte_r8_r9();
        t_selignored_r10();
        t_disable_r11();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule